// File: doc/BRIEF.md
# GPIO Bank Edge and Level Interrupt Detector

This block watches a bank of 32 general-purpose input lines and raises one summary interrupt toward the processor when any enabled line has a pending event. Each line first passes through a two-flop synchroniser. A per-line trigger mode then picks what counts as an event: a rising edge, a falling edge, either edge, a high level or a low level. Each event sets a sticky pending bit. Software clears a pending bit by writing a 1 to it.

A small word-addressed register bus gives access to the trigger modes, the per-line enable mask and the pending-status word. Reads return their data one cycle after the request. A line only takes part in detection while its pin is routed to the interrupt function. This routing is given by a per-line select input that comes from the pin multiplexer outside this block. At start-up, software masks every line by writing zero to the enable word. It then writes all ones to the status word to clear it.

Top module: `gpio_eint_bank`

## Requirements
- R1: After a synchronous active-low reset, `irq_out` is 0 and every register (config words at addresses 0-3, enable at address 4, status at address 5) reads as zero.
- R2: In mode 0 (rising), a 0-to-1 change on `pin_in[k]` sets status bit k on the third rising clock edge after the change. A 1-to-0 change does not set it.
- R3: In mode 1 (falling), only a 1-to-0 change on the line sets its status bit.
- R4: In mode 4 (both edges), every change on the synchronised line sets its status bit.
- R5: In mode 2 (level high), the status bit is set while the synchronised line is 1, and it is set again one cycle after a clear if the line is still 1.
- R6: In mode 3 (level low), the status bit is set while the synchronised line is 0, and it is set again after a clear while the line stays 0.
- R7: A write to address 5 clears exactly the status bits written as 1 and leaves the other bits unchanged. If a bit is cleared and a new event for that line occurs in the same cycle, the bit stays set.
- R8: `irq_out` equals the OR over all lines of (status AND enable). A status bit latches even while its line is disabled. Enable bit 1 unmasks a line.
- R9: The mode of line k sits in config word k/8, at bits [4*(k%8)+2 : 4*(k%8)]. Bit 4*(k%8)+3 reads as 0. A write to one config word leaves the other words unchanged.
- R10: A line whose `pin_irq_sel` bit is 0 never sets its status bit, whatever its input does.
- R11: `bus_rdata` presents the addressed word on the cycle after `bus_re` and is zero otherwise. Addresses 6 and 7 read as zero.
- R12: Mode values 5, 6 and 7 never set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_re` |
| pin_in | input | 32 | Asynchronous line inputs |
| pin_irq_sel | input | 32 | 1 when a pin is routed to the interrupt function |
| irq_out | output | 1 | Bank summary interrupt |

## Verification
A line change reaches its status bit on the third rising edge after the change. Two of those edges are synchroniser stages and one is the status register. `irq_out` follows the status and enable registers with no further delay. A register write takes effect at the next edge, and read data appears one edge after the read strobe. The bench keeps a behavioural model in which the synchroniser stages, the status word and the read register are all advanced at the same edge as the design. It compares `irq_out` and `bus_rdata` with the model at every falling edge, and it drives inputs only at falling edges. Directed checks also sample at falling edges and use counts of whole cycles: the rising-edge timing check looks at the second and third falling edges after the pin change.

// File: rtl/eint_pkg.sv
// Shared definitions for the GPIO bank interrupt detector.
// Assumes the trigger-mode encoding below is known to software.
package eint_pkg;

    typedef enum logic [2:0] {
        TRIG_RISE = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_HIGH = 3'd2,
        TRIG_LOW  = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    localparam int MODE_W = 3;   // width of one trigger-mode field
    localparam int SLOT_W = 4;   // bits one line occupies in a config word

endpackage

// File: rtl/eint_sync.sv
// Two-flop input synchroniser with a third stage holding the previous value.
// Assumes pin inputs are asynchronous; edges are later found as lvl != prev.
module eint_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] lvl_q;
    logic [N-1:0] prev_q;

    // Shift the pin samples through meta, level and previous stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/eint_detect.sv
// Per-line event evaluation and sticky pending-status bits.
// Assumes clr_i is a one-cycle write-1-to-clear mask; a new event wins
// over a clear in the same cycle. Unselected lines never raise events.
module eint_detect
    import eint_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      lvl_i,
    input  logic [N-1:0]      prev_i,
    input  logic [N-1:0]      sel_i,
    input  logic [N*MODE_W-1:0] mode_i,
    input  logic [N-1:0]      clr_i,
    output logic [N-1:0]      status_o
);
    logic [N-1:0] evt;
    logic [N-1:0] status_q;

    for (genvar k = 0; k < N; k++) begin : g_line
        logic [MODE_W-1:0] mode_k;
        logic              hit_k;
        assign mode_k = mode_i[k*MODE_W +: MODE_W];

        // Decide whether this line's trigger condition holds this cycle.
        always_comb begin
            case (mode_k)
                TRIG_RISE: hit_k =  lvl_i[k] & ~prev_i[k];
                TRIG_FALL: hit_k = ~lvl_i[k] &  prev_i[k];
                TRIG_HIGH: hit_k =  lvl_i[k];
                TRIG_LOW:  hit_k = ~lvl_i[k];
                TRIG_BOTH: hit_k =  lvl_i[k] ^  prev_i[k];
                default:   hit_k = 1'b0;
            endcase
        end

        assign evt[k] = hit_k & sel_i[k];

        // Unused mode codes must never let a clear bit become set.
        AST_BAD_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_k > 3'd4 && !status_q[k]) |=> !status_q[k]); // R12
    end

    // Hold pending bits: clear on write-1 mask, set on event (event wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | evt;
        end
    end

    assign status_o = status_q;

    AST_W1C_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q) & ~$past(clr_i)) ==
                  ($past(status_q) & ~$past(clr_i)))); // R7

    AST_UNSEL_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(sel_i) & ~$past(status_q)) == '0)); // R10

endmodule

// File: rtl/eint_regs.sv
// Register file: per-line trigger modes, enable mask, status read-back
// and the write-1-to-clear strobe. Assumes single-cycle write strobes and
// registered reads with one cycle of latency; unmapped addresses read 0.
module eint_regs
    import eint_pkg::*;
#(
    parameter int N      = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic                re_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [N-1:0]        status_i,
    output logic [N*MODE_W-1:0] mode_o,
    output logic [N-1:0]        en_o,
    output logic [N-1:0]        clr_o,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int LINES_PER_WORD = DATA_W / SLOT_W;
    localparam int CFG_WORDS      = N / LINES_PER_WORD;
    localparam logic [ADDR_W-1:0] ADDR_EN = ADDR_W'(CFG_WORDS);
    localparam logic [ADDR_W-1:0] ADDR_ST = ADDR_W'(CFG_WORDS + 1);

    logic [MODE_W-1:0] mode_q [N];
    logic [N-1:0]      en_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    for (genvar k = 0; k < N; k++) begin : g_mode
        localparam int WORD = k / LINES_PER_WORD;
        localparam int SLOT = k % LINES_PER_WORD;

        // Capture this line's mode field when its config word is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[k] <= '0;
            end else if (we_i && addr_i == ADDR_W'(WORD)) begin
                mode_q[k] <= wdata_i[SLOT*SLOT_W +: MODE_W];
            end
        end

        assign mode_o[k*MODE_W +: MODE_W] = mode_q[k];
    end

    // Load the enable mask on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we_i && addr_i == ADDR_EN) begin
            en_q <= wdata_i[N-1:0];
        end
    end

    // Turn a status write into a one-cycle clear mask.
    always_comb begin
        clr_o = '0;
        if (we_i && addr_i == ADDR_ST) begin
            clr_o = wdata_i[N-1:0];
        end
    end

    // Select the word addressed by the current read.
    always_comb begin
        rd_word = '0;
        if (int'(addr_i) < CFG_WORDS) begin
            for (int s = 0; s < LINES_PER_WORD; s++) begin
                rd_word[s*SLOT_W +: MODE_W] = mode_q[int'(addr_i)*LINES_PER_WORD + s];
            end
        end else if (addr_i == ADDR_EN) begin
            rd_word[N-1:0] = en_q;
        end else if (addr_i == ADDR_ST) begin
            rd_word[N-1:0] = status_i;
        end
    end

    // Register read data; zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= re_i ? rd_word : '0;
        end
    end

    assign en_o    = en_q;
    assign rdata_o = rdata_q;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && rdata_q == '0)); // R1

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> (rdata_q == '0)); // R11

endmodule

// File: rtl/gpio_eint_bank.sv
// GPIO bank interrupt detector top: synchroniser, per-line detection,
// register file and the summary interrupt. Assumes pins are asynchronous
// and that pin_irq_sel comes from the pin multiplexer.
module gpio_eint_bank
    import eint_pkg::*;
#(
    parameter int N      = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      pin_in,
    input  logic [N-1:0]      pin_irq_sel,
    output logic              irq_out
);
    logic [N-1:0]        lvl;
    logic [N-1:0]        prev;
    logic [N-1:0]        status;
    logic [N-1:0]        en;
    logic [N-1:0]        clr;
    logic [N*MODE_W-1:0] mode;

    eint_sync #(.N(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    eint_detect #(.N(N)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl),
        .prev_i   (prev),
        .sel_i    (pin_irq_sel),
        .mode_i   (mode),
        .clr_i    (clr),
        .status_o (status)
    );

    eint_regs #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (bus_we),
        .re_i     (bus_re),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .status_i (status),
        .mode_o   (mode),
        .en_o     (en),
        .clr_o    (clr),
        .rdata_o  (bus_rdata)
    );

    // Summary line: any pending line that is also unmasked.
    assign irq_out = |(status & en);

    AST_NO_PENDING_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq_out); // R8

endmodule

// File: tb/gpio_eint_bank_bench.sv
module gpio_eint_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_irq_sel = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_eint_bank u_gpio_eint_bank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_irq_sel(pin_irq_sel), .irq_out(irq_out)
    );

    // Behavioural reference model, advanced at every rising edge.
    logic [31:0] m_s1, m_s2, m_prev, m_st, m_en, m_rd;
    int          m_mode [32];

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] w = '0;
        if (a < 3'd4) begin
            for (int s = 0; s < 8; s++) w[s*4 +: 3] = 3'(m_mode[a*8 + s]);
        end else if (a == 3'd4) w = m_en;
        else if (a == 3'd5) w = m_st;
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_en = '0; m_rd = '0;
            for (int k = 0; k < 32; k++) m_mode[k] = 0;
        end else begin
            logic [31:0] ev, clr, nrd;
            ev = '0;
            for (int k = 0; k < 32; k++) begin
                bit h;
                case (m_mode[k])
                    0: h = m_s2[k] && !m_prev[k];
                    1: h = !m_s2[k] && m_prev[k];
                    2: h = m_s2[k];
                    3: h = !m_s2[k];
                    4: h = m_s2[k] != m_prev[k];
                    default: h = 0;
                endcase
                ev[k] = h && pin_irq_sel[k];
            end
            nrd = bus_re ? model_read(bus_addr) : '0;
            clr = (bus_we && bus_addr == 3'd5) ? bus_wdata : '0;
            if (bus_we && bus_addr < 3'd4)
                for (int s = 0; s < 8; s++) m_mode[bus_addr*8 + s] = int'(bus_wdata[s*4 +: 3]);
            if (bus_we && bus_addr == 3'd4) m_en = bus_wdata;
            m_st = (m_st & ~clr) | ev;
            m_rd = nrd;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R8 summary, R11 read data).
    always @(negedge clk) begin
        if (started && !finished) begin
            check(irq_out == |(m_st & m_en), "R8 irq_out vs model", 32'(irq_out), 32'(|(m_st & m_en)));
            check(bus_rdata == m_rd, "R11 rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_re = 1'b1; bus_addr = a;
        @(negedge clk); bus_re = 1'b0; d = bus_rdata;
    endtask

    task automatic expect_read(input logic [2:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        bus_read(a, d);
        check(d == e, req, d, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        // R1: reset state
        check(irq_out == 1'b0, "R1 irq after reset", 32'(irq_out), 0);
        for (int a = 0; a < 6; a++) expect_read(3'(a), 32'h0, "R1 register after reset");
        // Start-up sequence: mask all, clear all
        bus_write(3'd4, 32'h0);
        bus_write(3'd5, 32'hFFFF_FFFF);
        pin_irq_sel = 32'hFFFF_FFBF;   // line 6 not routed to interrupts
        // Lines 0..5: rise, fall, high, low, both, unused code 5; bit 31 stray
        bus_write(3'd0, 32'h8054_3210);
        expect_read(3'd0, 32'h0054_3210, "R9 config readback masks slot bit 3");
        expect_read(3'd1, 32'h0, "R9 other config word untouched");
        bus_write(3'd5, 32'hFFFF_FFFF);
        idle(5);
        expect_read(3'd5, 32'h0000_0008, "R6 level low re-pends after clear");
        check(irq_out == 1'b0, "R8 status latched but masked", 32'(irq_out), 0);
        bus_write(3'd4, 32'h0000_0008);
        check(irq_out == 1'b1, "R8 unmask raises irq", 32'(irq_out), 1);
        // Rising inputs on lines 0..6
        pin_in = 32'h0000_007F;
        idle(5);
        expect_read(3'd5, 32'h0000_001D, "R2 R3 R4 R5 R10 R12 after rising inputs");
        bus_write(3'd5, 32'h0000_001F);
        idle(5);
        expect_read(3'd5, 32'h0000_0004, "R5 level high re-pends after clear");
        // Falling inputs
        pin_in = 32'h0;
        idle(5);
        expect_read(3'd5, 32'h0000_001E, "R3 R4 R6 after falling inputs, R2 no fall");
        bus_write(3'd5, 32'h0000_0002);
        expect_read(3'd5, 32'h0000_001C, "R7 clears only written bits");
        bus_write(3'd5, 32'h0000_0008);
        expect_read(3'd5, 32'h0000_001C, "R7 event in clear cycle keeps bit");
        bus_write(3'd5, 32'h0000_0014);
        expect_read(3'd5, 32'h0000_0008, "R7 partial clear");
        // R2 timing: rising edge reaches irq on the third edge
        bus_write(3'd4, 32'h0000_0001);
        check(irq_out == 1'b0, "R2 irq idle before edge", 32'(irq_out), 0);
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(irq_out == 1'b0, "R2 not yet after two edges", 32'(irq_out), 0);
        @(negedge clk);
        check(irq_out == 1'b1, "R2 irq on third edge", 32'(irq_out), 1);
        // R11 address map
        expect_read(3'd6, 32'h0, "R11 address 6 reads zero");
        expect_read(3'd7, 32'h0, "R11 address 7 reads zero");
        expect_read(3'd4, 32'h0000_0001, "R11 enable readback");
        // R9 upper config word, line 30 in both-edge mode
        bus_write(3'd3, 32'h0400_0000);
        expect_read(3'd3, 32'h0400_0000, "R9 config word 3 readback");
        expect_read(3'd0, 32'h0054_3210, "R9 word 0 unchanged by word 3 write");
        bus_write(3'd5, 32'h0000_0001);
        pin_in[30] = 1'b1;
        idle(5);
        expect_read(3'd5, 32'h4000_0008, "R4 line 30 both-edge pends");
        idle(2);
        finish_run();
    end
endmodule